// File: doc/BRIEF.md
# In-Order Pipeline Stall Controller

This block decides, each cycle, whether the instruction sitting in the decode stage of an in-order, single-issue pipeline may move on to execution. The pipeline has two execution paths. Integer and load instructions take a one-cycle execute stage and then pass through memory access and write-back. Floating-point multiplies take `MUL_STAGES` execute stages (seven by default) and then pass through memory access and write-back. Every instruction picks up its operands at the start of its first execute cycle.

The decoder presents the instruction in decode as a valid/ready stream: class, two source register numbers and one destination register number, with `id_valid`. The block keeps a short history of the instructions already issued. It compares each source against the destination of the closest earlier writer of that register. When the value would not be ready in time, it drops `id_ready`, which freezes fetch and decode. While `id_ready` is low the decoder must hold its payload unchanged. An instruction issues in the cycle where `id_valid && id_ready`. A stall therefore delays every later instruction by the same number of cycles.

`fwd_en` selects one of two timing models. With forwarding, results come from the bypass network. Without it, a consumer may only read the register file in the producer's write-back cycle or later. The register file is written in the first half of a cycle and read in the second half. For each issuing instruction the block reports where each operand comes from, and it keeps a saturating count of stalled cycles.

Top module: `hz_stall_ctrl`

## Requirements
- R1: After reset, with `id_valid` low, `id_ready` is 1, both forwarding selects are 0 and `stall_cnt` is 0.
- R2: With forwarding on, a consumer issued right after a load of one of its sources waits exactly one cycle. The minimum issue distance from a load is 2 cycles.
- R3: With forwarding off, the minimum issue distance from a load or integer producer to its consumer is 3 cycles, so an adjacent load-use pair waits two cycles.
- R4: The minimum issue distance from a multiply producer (class 2) is `MUL_STAGES` cycles with forwarding (6 stall cycles for an adjacent consumer) and `MUL_STAGES`+2 cycles without (8 stall cycles).
- R5: With forwarding on, an integer producer (class 0) creates no stall for the next instruction, and its operand select reads 1.
- R6: Register 0 never creates a dependency. An instruction of class 3, which has no result, is never a producer.
- R7: Only the closest earlier writer of a source register sets that source's timing. An older, slower writer of the same register is ignored.
- R8: When two independent instructions separate a load from its consumer, no stall occurs in either mode.
- R9: `id_ready` is 1 whenever `id_valid` is 0. An instruction issues in the cycle where both are 1.
- R10: Forwarding selects are 0 unless an instruction issues with forwarding on. Otherwise the select is 1 when the producer is in its memory stage during the consumer's first execute cycle, 2 when it is in write-back, and 0 in all other cases. The value 3 never appears.
- R11: `stall_cnt` rises by one after each cycle with `id_valid` high and `id_ready` low, holds otherwise, and saturates at its maximum.
- R12: Instruction issue cycles follow the in-order schedule: each instruction issues at the later of one cycle after its predecessor and the minimum distances above from each source's producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_en | input | 1 | 1 selects the forwarding timing model |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_ready | output | 1 | Decode instruction may issue this cycle |
| id_class | input | 2 | 0 integer, 1 load, 2 multiply, 3 no result |
| id_src_a | input | REG_W | First source register (0 means unused) |
| id_src_b | input | REG_W | Second source register (0 means unused) |
| id_dst | input | REG_W | Destination register |
| fwd_sel_a | output | 2 | Operand source for the first source |
| fwd_sel_b | output | 2 | Operand source for the second source |
| stall_cnt | output | STALL_CNT_W | Saturating count of stalled cycles |

## Verification
The corner cases are the exact stall lengths after adjacent loads and multiplies in both modes. A design with an off-by-one age threshold would issue one cycle early and read a stale operand, or one cycle late and waste a slot. Register 0 and class-3 producers are covered because a design that matched them would stall on instructions with no true dependency. Sequences in which a fast writer follows a slow writer of the same register check that the closest producer decides; a design scanning from the oldest end would stall for the multiply. Random load/multiply streams then check every issue cycle and operand select against an independent schedule, and long runs drive the stall counter into saturation, where a wrapping counter would fall back to small values.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_FMUL  = 2'd2,
    CLS_NORES = 2'd3
  } op_cls_e;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;

  // Producer age (cycles after its first execute cycle) at which a
  // consumer may start executing one cycle later.
  function automatic int ready_age(op_cls_e c, logic fwd, int ms);
    int r;
    if (fwd) begin
      case (c)
        CLS_LOAD: r = 1;
        CLS_FMUL: r = ms - 1;
        default:  r = 0;
      endcase
    end else begin
      r = (c == CLS_FMUL) ? ms + 1 : 2;
    end
    return r;
  endfunction

  function automatic int mem_age(op_cls_e c, int ms);
    return (c == CLS_FMUL) ? ms : 1;
  endfunction

  function automatic int wb_age(op_cls_e c, int ms);
    return (c == CLS_FMUL) ? ms + 1 : 2;
  endfunction

endpackage

// File: rtl/hz_pipe_track.sv
module hz_pipe_track
  import hz_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int DEPTH = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_vld,
  input  logic [REG_W-1:0]            push_dst,
  input  logic [1:0]                  push_cls,
  output logic [DEPTH-1:0]            trk_vld,
  output logic [DEPTH-1:0][REG_W-1:0] trk_dst,
  output logic [DEPTH-1:0][1:0]       trk_cls
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_vld[0] <= 1'b0;
      trk_dst[0] <= '0;
      trk_cls[0] <= '0;
    end else begin
      trk_vld[0] <= push_vld;
      trk_dst[0] <= push_dst;
      trk_cls[0] <= push_cls;
    end
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        trk_vld[k] <= 1'b0;
        trk_dst[k] <= '0;
        trk_cls[k] <= '0;
      end else begin
        trk_vld[k] <= trk_vld[k-1];
        trk_dst[k] <= trk_dst[k-1];
        trk_cls[k] <= trk_cls[k-1];
      end
    end
  end

endmodule

// File: rtl/hz_src_scan.sv
module hz_src_scan
  import hz_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int DEPTH      = 9,
  parameter int MUL_STAGES = 7
) (
  input  logic [REG_W-1:0]            src_i,
  input  logic                        fwd_en_i,
  input  logic [DEPTH-1:0]            trk_vld,
  input  logic [DEPTH-1:0][REG_W-1:0] trk_dst,
  input  logic [DEPTH-1:0][1:0]       trk_cls,
  output logic                        blocked_o,
  output logic [1:0]                  sel_o
);

  logic    hit;
  int      hk;
  int      age;
  op_cls_e hc;

  always_comb begin
    hit = 1'b0;
    hk  = 0;
    hc  = CLS_ALU;
    // Scan from oldest to youngest so the youngest match is kept.
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (trk_vld[k] && (trk_dst[k] == src_i)) begin
        hit = 1'b1;
        hk  = k;
        hc  = op_cls_e'(trk_cls[k]);
      end
    end
    if (src_i == '0) hit = 1'b0;

    blocked_o = hit && (hk < ready_age(hc, fwd_en_i, MUL_STAGES));

    age   = hk + 1;
    sel_o = FWD_RF;
    if (hit && fwd_en_i) begin
      if (age == mem_age(hc, MUL_STAGES))     sel_o = FWD_MEM;
      else if (age == wb_age(hc, MUL_STAGES)) sel_o = FWD_WB;
    end
  end

endmodule

// File: rtl/hz_stall_cnt.sv
module hz_stall_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt_o <= '0;
    else if (stall_i && cnt_o != CNT_TOP) cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter int MUL_STAGES  = 7,
  parameter int STALL_CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fwd_en,
  input  logic                   id_valid,
  output logic                   id_ready,
  input  logic [1:0]             id_class,
  input  logic [REG_W-1:0]       id_src_a,
  input  logic [REG_W-1:0]       id_src_b,
  input  logic [REG_W-1:0]       id_dst,
  output logic [1:0]             fwd_sel_a,
  output logic [1:0]             fwd_sel_b,
  output logic [STALL_CNT_W-1:0] stall_cnt
);

  localparam int DEPTH = MUL_STAGES + 2;
  localparam int NSRC  = 2;

  logic [DEPTH-1:0]            trk_vld;
  logic [DEPTH-1:0][REG_W-1:0] trk_dst;
  logic [DEPTH-1:0][1:0]       trk_cls;

  logic [REG_W-1:0] src   [NSRC];
  logic             blk   [NSRC];
  logic [1:0]       sel   [NSRC];
  logic             hazard;
  logic             issue;
  logic             push_vld;

  assign src[0] = id_src_a;
  assign src[1] = id_src_b;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hz_src_scan #(
      .REG_W     (REG_W),
      .DEPTH     (DEPTH),
      .MUL_STAGES(MUL_STAGES)
    ) u_scan (
      .src_i    (src[s]),
      .fwd_en_i (fwd_en),
      .trk_vld  (trk_vld),
      .trk_dst  (trk_dst),
      .trk_cls  (trk_cls),
      .blocked_o(blk[s]),
      .sel_o    (sel[s])
    );
  end

  assign hazard   = blk[0] | blk[1];
  assign issue    = id_valid && !hazard;
  assign id_ready = !(id_valid && hazard);
  assign push_vld = issue && (op_cls_e'(id_class) != CLS_NORES) && (id_dst != '0);

  assign fwd_sel_a = issue ? sel[0] : FWD_RF;
  assign fwd_sel_b = issue ? sel[1] : FWD_RF;

  hz_pipe_track #(
    .REG_W(REG_W),
    .DEPTH(DEPTH)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_vld(push_vld),
    .push_dst(id_dst),
    .push_cls(id_class),
    .trk_vld (trk_vld),
    .trk_dst (trk_dst),
    .trk_cls (trk_cls)
  );

  hz_stall_cnt #(
    .CNT_W(STALL_CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .stall_i(id_valid && hazard),
    .cnt_o  (stall_cnt)
  );

endmodule

// File: rtl/hz_stall_ctrl_chk.sv
module hz_stall_ctrl_chk #(
  parameter int REG_W       = 5,
  parameter int STALL_CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fwd_en,
  input logic                   id_valid,
  input logic                   id_ready,
  input logic [1:0]             id_class,
  input logic [REG_W-1:0]       id_src_a,
  input logic [REG_W-1:0]       id_src_b,
  input logic [REG_W-1:0]       id_dst,
  input logic [1:0]             fwd_sel_a,
  input logic [1:0]             fwd_sel_b,
  input logic [STALL_CNT_W-1:0] stall_cnt
);

  localparam logic [STALL_CNT_W-1:0] CNT_TOP = '1;

  logic issue;
  assign issue = id_valid && id_ready;

  a_r9_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> id_ready);

  a_r6_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_src_a == '0 && id_src_b == '0) |-> id_ready);

  a_r11_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !id_ready && stall_cnt != CNT_TOP) |=> stall_cnt == $past(stall_cnt) + 1'b1);

  a_r11_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_valid && !id_ready) |=> $stable(stall_cnt));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_en || !issue) |-> (fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0));

  a_r10_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_a != 2'd3 && fwd_sel_b != 2'd3));

  a_r2_load_use: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && $past(fwd_en) && $past(issue && id_class == 2'd1 && id_dst != '0)
     && id_valid && id_src_a == $past(id_dst)) |-> !id_ready);

  a_r4_mul_use: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue && id_class == 2'd2 && id_dst != '0)
     && id_valid && id_src_a == $past(id_dst)) |-> !id_ready);

  a_r5_alu_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && $past(fwd_en) && $past(issue && id_class == 2'd0 && id_dst != '0)
     && id_valid && id_src_a == $past(id_dst) && id_src_b == '0)
    |-> (id_ready && fwd_sel_a == 2'd1));

endmodule

bind hz_stall_ctrl hz_stall_ctrl_chk #(
  .REG_W      (REG_W),
  .STALL_CNT_W(STALL_CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fwd_en   (fwd_en),
  .id_valid (id_valid),
  .id_ready (id_ready),
  .id_class (id_class),
  .id_src_a (id_src_a),
  .id_src_b (id_src_b),
  .id_dst   (id_dst),
  .fwd_sel_a(fwd_sel_a),
  .fwd_sel_b(fwd_sel_b),
  .stall_cnt(stall_cnt)
);

// File: tb/sim_hz_stall_ctrl.sv
`timescale 1ns/1ps
module sim_hz_stall_ctrl;

  localparam int RW   = 5;
  localparam int CW   = 8;
  localparam int CTOP = 255;
  localparam int MAXN = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fwd_en = 1'b0;
  logic          id_valid = 1'b0;
  logic          id_ready;
  logic [1:0]    id_class = '0;
  logic [RW-1:0] id_src_a = '0;
  logic [RW-1:0] id_src_b = '0;
  logic [RW-1:0] id_dst = '0;
  logic [1:0]    fwd_sel_a, fwd_sel_b;
  logic [CW-1:0] stall_cnt;

  always #2.5 clk = ~clk;

  hz_stall_ctrl #(.REG_W(RW), .MUL_STAGES(7), .STALL_CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .id_valid(id_valid),
    .id_ready(id_ready), .id_class(id_class), .id_src_a(id_src_a),
    .id_src_b(id_src_b), .id_dst(id_dst), .fwd_sel_a(fwd_sel_a),
    .fwd_sel_b(fwd_sel_b), .stall_cnt(stall_cnt)
  );

  int nchk = 0;
  int nfail = 0;
  int pc[MAXN], pa[MAXN], pb[MAXN], pd[MAXN];
  int et[MAXN], eha[MAXN], ehb[MAXN];
  int at[MAXN], aha[MAXN], ahb[MAXN];
  int cnt_total = 0;
  int last_stalls = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Minimum issue distance from a producer (R2..R5).
  function automatic int min_gap(int c, bit f);
    if (f) return (c == 1) ? 2 : (c == 2) ? 7 : 1;
    return (c == 2) ? 9 : 3;
  endfunction

  function automatic int exp_sel(int c, int age, bit f);
    int m, w;
    m = (c == 2) ? 7 : 1;
    w = (c == 2) ? 8 : 2;
    if (!f) return 0;
    if (age == m) return 1;
    if (age == w) return 2;
    return 0;
  endfunction

  // Nearest earlier writer of register r before instruction i, or -1 (R6, R7).
  function automatic int producer(int i, int r);
    int p = -1;
    if (r == 0) return -1;
    for (int j = 0; j < i; j++)
      if (pc[j] != 3 && pd[j] == r) p = j;
    return p;
  endfunction

  task automatic model(int n, bit f);
    for (int i = 0; i < n; i++) begin
      int t, ja, jb;
      t  = (i == 0) ? 0 : et[i-1] + 1;
      ja = producer(i, pa[i]);
      jb = producer(i, pb[i]);
      if (ja >= 0 && et[ja] + min_gap(pc[ja], f) > t) t = et[ja] + min_gap(pc[ja], f);
      if (jb >= 0 && et[jb] + min_gap(pc[jb], f) > t) t = et[jb] + min_gap(pc[jb], f);
      et[i]  = t;
      eha[i] = (ja >= 0) ? exp_sel(pc[ja], t - et[ja], f) : 0;
      ehb[i] = (jb >= 0) ? exp_sel(pc[jb], t - et[jb], f) : 0;
    end
  endtask

  // Called at a negedge; returns at a negedge with the pipeline drained.
  task automatic run_prog(int n, bit f, string tag);
    int idx, cyc, obs;
    model(n, f);
    fwd_en = f;
    idx = 0; cyc = 0; obs = 0;
    while (idx < n && cyc < 400) begin
      id_valid = 1'b1;
      id_class = pc[idx][1:0];
      id_src_a = pa[idx][RW-1:0];
      id_src_b = pb[idx][RW-1:0];
      id_dst   = pd[idx][RW-1:0];
      #1;
      if (id_ready) begin
        at[idx] = cyc; aha[idx] = fwd_sel_a; ahb[idx] = fwd_sel_b;
        idx++;
      end else obs++;
      cyc++;
      @(negedge clk);
    end
    chk(idx == n, {tag, " R12 run completes"}, idx, n);
    id_valid = 1'b0;
    for (int k = 0; k < 12; k++) @(negedge clk);
    #1;
    chk(id_ready == 1'b1, {tag, " R9 idle ready"}, id_ready, 1);
    for (int i = 0; i < idx; i++) begin
      chk(at[i] == et[i], $sformatf("%s R12 issue cycle of instr %0d", tag, i), at[i], et[i]);
      chk(aha[i] == eha[i], $sformatf("%s R10 select a instr %0d", tag, i), aha[i], eha[i]);
      chk(ahb[i] == ehb[i], $sformatf("%s R10 select b instr %0d", tag, i), ahb[i], ehb[i]);
    end
    last_stalls = obs;
    chk(obs == et[n-1] - (n - 1), {tag, " R12 stall total"}, obs, et[n-1] - (n - 1));
    cnt_total += et[n-1] - (n - 1);
    chk(int'(stall_cnt) == ((cnt_total > CTOP) ? CTOP : cnt_total), {tag, " R11 stall count"},
        stall_cnt, (cnt_total > CTOP) ? CTOP : cnt_total);
    @(negedge clk);
  endtask

  task automatic set_i(int i, int c, int a, int b, int d);
    pc[i] = c; pa[i] = a; pb[i] = b; pd[i] = d;
  endtask

  task automatic load_doc_seq();
    set_i(0, 1, 2, 0, 1);  set_i(1, 2, 1, 1, 2);
    set_i(2, 1, 3, 0, 4);  set_i(3, 2, 4, 4, 6);
    set_i(4, 1, 5, 0, 8);  set_i(5, 2, 8, 8, 10);
  endtask

  task automatic load_reorder();
    set_i(0, 1, 2, 0, 1);  set_i(1, 1, 3, 0, 4);
    set_i(2, 1, 5, 0, 8);  set_i(3, 2, 1, 1, 2);
    set_i(4, 2, 4, 4, 6);  set_i(5, 2, 8, 8, 10);
  endtask

  initial begin
    #150000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(id_ready == 1'b1, "R1 ready after reset", id_ready, 1);
    chk(stall_cnt == '0, "R1 stall count after reset", stall_cnt, 0);
    chk(fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0, "R1 selects after reset", fwd_sel_a, 0);
    @(negedge clk);

    // R2 / R3: load-multiply chain
    load_doc_seq();  run_prog(6, 1'b1, "R2 chain fwd");
    chk(last_stalls == 3, "R2 chain stalls with forwarding", last_stalls, 3);
    load_doc_seq();  run_prog(6, 1'b0, "R3 chain nofwd");
    chk(last_stalls == 6, "R3 chain stalls without forwarding", last_stalls, 6);

    // R8: reordered, loads separated from consumers
    load_reorder();  run_prog(6, 1'b1, "R8 reorder fwd");
    chk(last_stalls == 0, "R8 reorder stalls fwd", last_stalls, 0);
    load_reorder();  run_prog(6, 1'b0, "R8 reorder nofwd");
    chk(last_stalls == 0, "R8 reorder stalls nofwd", last_stalls, 0);

    // R4: multiply producer
    set_i(0, 2, 1, 2, 3); set_i(1, 0, 3, 0, 4);
    run_prog(2, 1'b1, "R4 mul fwd");
    chk(last_stalls == 6, "R4 mul-use stalls fwd", last_stalls, 6);
    set_i(0, 2, 1, 2, 3); set_i(1, 0, 0, 3, 4);
    run_prog(2, 1'b0, "R4 mul nofwd");
    chk(last_stalls == 8, "R4 mul-use stalls nofwd", last_stalls, 8);

    // R5: integer producer
    set_i(0, 0, 1, 2, 5); set_i(1, 0, 5, 0, 6);
    run_prog(2, 1'b1, "R5 alu fwd");
    chk(last_stalls == 0, "R5 alu-use stalls fwd", last_stalls, 0);
    chk(aha[1] == 1, "R5 alu-use select", aha[1], 1);
    set_i(0, 0, 1, 2, 5); set_i(1, 0, 5, 0, 6);
    run_prog(2, 1'b0, "R5 alu nofwd");
    chk(last_stalls == 2, "R5 alu-use stalls nofwd", last_stalls, 2);

    // R6: register 0 and no-result class
    set_i(0, 1, 1, 0, 0); set_i(1, 2, 0, 0, 9);
    set_i(2, 3, 1, 2, 7); set_i(3, 0, 7, 7, 8);
    run_prog(4, 1'b0, "R6 zero/nores");
    chk(last_stalls == 0, "R6 no false dependency", last_stalls, 0);

    // R7: nearest producer wins
    set_i(0, 2, 2, 3, 1); set_i(1, 0, 4, 0, 1); set_i(2, 0, 1, 0, 5);
    run_prog(3, 1'b1, "R7 nearest fwd");
    chk(last_stalls == 0, "R7 younger integer writer decides", last_stalls, 0);

    // Random load/multiply streams
    for (int p = 0; p < 40; p++) begin
      for (int i = 0; i < 16; i++)
        set_i(i, int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
      run_prog(16, bit'($urandom_range(0, 1)), "R12 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule